// File: doc/BRIEF.md
# Receive FIFO with trigger and timeout

This block is the receive-side byte queue of a serial port controller. The deserialiser pushes each completed character into a 16-entry queue, and the host pops characters from the head. The block tells the host three things: whether data is waiting, whether the fill level has reached a programmable trigger threshold, and whether characters have sat unread for too long.

An 8-bit control register write port sets up the queue. One bit enables it, and two self-clearing bits flush the receive queue and request a flush of the transmit queue, which lives outside this block. A two-bit field picks the trigger threshold, and one further bit is kept for software. Writing a value whose enable bit differs from the stored one flushes both queues.

A character-timeout detector counts bit-time ticks. It converts them into character times from the current frame setup: data width, parity on or off, and one or two stop bits. If four character times pass with no queue activity while data remains, it raises a timeout-pending flag.

Top module: `serial_rx_queue`

## Requirements
- R1: After synchronous active-low reset: count 0, data_ready 0, trig_hit 0, timeout_pend 0, overrun 0, tx_flush 0, ctl_q 0x00 (queue disabled), pop_data 0x00.
- R2: While enabled, the queue holds up to 16 bytes and returns them in push order. pop_data shows the head byte combinationally, and pop advances past it. Head and tail indices wrap after entry 15, and count gives the occupancy.
- R3: A push while count is 16 (and no pop in the same cycle) is dropped and sets overrun. Overrun stays set until an ovr_clr pulse clears it.
- R4: While count is 0, pop_data is 0x00 and a pop changes neither count nor any flag.
- R5: data_ready is 1 exactly when count is nonzero, so it falls only when the last byte is popped.
- R6: Control bits 7:6 select the trigger threshold: 00 selects 1 byte, 01 selects 4, 10 selects 8 and 11 selects 14. trig_hit is 1 while the queue is enabled and count is at or above the threshold.
- R7: A control write stores only bits 7, 6, 3 and 0 (the value ANDed with 0xC9) into ctl_q. Bit 0 is the queue enable.
- R8: A control write with bit 1 set empties the receive queue, stops the timeout countdown and clears timeout_pend. A control write with bit 2 set pulses tx_flush high for the one cycle after the write.
- R9: A control write whose bit 0 differs from ctl_q bit 0 acts as if bits 1 and 2 were both set.
- R10: While the queue is disabled (ctl_q bit 0 = 0), push is ignored: count stays 0 and overrun does not change.
- R11: One character time lasts 1 + (5 + data_sel) + parity_on + (1 + stop_two) bit ticks, where data_sel is 0 to 3 for 5 to 8 data bits.
- R12: Each accepted push restarts the timeout countdown, and so does each pop that leaves data in the queue. After four character times of bit ticks, counted from the cycle after the restart, timeout_pend is set if count is still nonzero. It is not set if the queue is empty.
- R13: A pop clears timeout_pend. Further pushes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| push | input | 1 | Deserialiser character strobe |
| push_data | input | 8 | Received character |
| pop | input | 1 | Host read strobe |
| pop_data | output | 8 | Head character, 0x00 when empty |
| bit_tick | input | 1 | One pulse per serial bit time |
| data_sel | input | 2 | Data width code, 0..3 for 5..8 bits |
| parity_on | input | 1 | Frame carries a parity bit |
| stop_two | input | 1 | Frame carries two stop bits |
| ovr_clr | input | 1 | Clears the overrun flag |
| count | output | 5 | Queue occupancy |
| data_ready | output | 1 | Queue not empty |
| trig_hit | output | 1 | Occupancy at or above trigger threshold |
| timeout_pend | output | 1 | Character timeout pending |
| overrun | output | 1 | A push was dropped on a full queue |
| ctl_q | output | 8 | Retained control register bits |
| tx_flush | output | 1 | One-cycle transmit queue flush request |

## Verification
The queue path is tested in three ways. A full fill with distinct bytes checks order and the full boundary. A second pass starts at a shifted pointer position so that the indices wrap. Pops on an empty queue check that nothing moves. Each trigger code is tried at exactly one below and exactly at its threshold, which separates the four decodes from one another and from an off-by-one compare. The timeout is probed one tick before and at the expiry tick for three frame lengths. The same probe is repeated after a restart, after a receive reset and after the queue drains, which tells a correct restart and cancel apart from a free-running or never-restarting counter.

// File: rtl/serial_rx_queue_pkg.sv
// Shared constants and helpers for the receive queue.
// Assumes an 8-bit control register; bit positions below are decoded by neighbours.
package serial_rx_queue_pkg;

    localparam int CTL_W       = 8;
    localparam int EN_BIT      = 0;
    localparam int RXRST_BIT   = 1;
    localparam int TXRST_BIT   = 2;
    localparam logic [CTL_W-1:0] KEEP_MASK = 8'hC9;

    // Decoded control actions produced by a single register write.
    typedef struct packed {
        logic rx_flush;
        logic tx_flush;
        logic toggled;
    } ctl_action_t;

    // Trigger threshold in bytes for the two-bit selector field.
    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        case (sel)
            2'b00:   trig_level = 5'd1;
            2'b01:   trig_level = 5'd4;
            2'b10:   trig_level = 5'd8;
            default: trig_level = 5'd14;
        endcase
    endfunction

    // Bit ticks in one character: start + data + optional parity + stop bits.
    function automatic logic [3:0] char_ticks(input logic [1:0] dsel,
                                              input logic       par,
                                              input logic       stop2);
        char_ticks = 4'd7 + {2'b00, dsel} + {3'b000, par} + {3'b000, stop2};
    endfunction

endpackage

// File: rtl/serial_rx_queue_ctl.sv
// Control register for the receive queue.
// Stores the sticky bits, decodes self-clearing flush bits and treats an
// enable toggle as a request to flush both queues.
module serial_rx_queue_ctl
    import serial_rx_queue_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] ctl_q,
    output logic             rx_flush,
    output logic             tx_flush_q
);

    ctl_action_t act;

    // Decode the actions of the current write.
    always_comb begin
        act.toggled  = we && (wdata[EN_BIT] != ctl_q[EN_BIT]);
        act.rx_flush = we && (wdata[RXRST_BIT] || act.toggled);
        act.tx_flush = we && (wdata[TXRST_BIT] || act.toggled);
    end

    assign rx_flush = act.rx_flush;

    // Hold the retained control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (we) begin
            ctl_q <= wdata & KEEP_MASK;
        end
    end

    // Register the one-cycle transmit flush request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_flush_q <= 1'b0;
        end else begin
            tx_flush_q <= act.tx_flush;
        end
    end

endmodule

// File: rtl/serial_rx_queue_store.sv
// Circular byte store with head/tail indices, occupancy count and overrun flag.
// Assumes flush has priority over push and pop; a pop on empty is ignored.
module serial_rx_queue_store #(
    parameter  int DEPTH = 16,
    parameter  int DW    = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             flush,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    input  logic             ovr_clr,
    output logic [DW-1:0]    pop_data,
    output logic [CNT_W-1:0] count,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             overrun
);

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [DW-1:0]    slot [DEPTH];
    logic             full;
    logic             empty;
    logic             push_drop;

    // Classify this cycle's push and pop requests.
    always_comb begin
        full      = (count == CNT_W'(DEPTH));
        empty     = (count == '0);
        pop_ok    = en && pop && !empty && !flush;
        push_ok   = en && push && !flush && (!full || pop_ok);
        push_drop = en && push && !flush && full && !pop_ok;
    end

    // One register per entry, written when the tail index selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (push_ok && (wr_ptr == PTR_W'(g))) begin
                slot[g] <= push_data;
            end
        end
    end

    // Present the head byte, or zero when nothing is queued.
    assign pop_data = empty ? '0 : slot[rd_ptr];

    // Advance the tail index on an accepted push, wrapping at the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
        end else if (push_ok) begin
            wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        end
    end

    // Advance the head index on an accepted pop, wrapping at the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
        end else if (pop_ok) begin
            rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Track occupancy separately from the indices.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            count <= '0;
        end else begin
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Sticky overrun flag; a new drop wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (push_drop) begin
            overrun <= 1'b1;
        end else if (ovr_clr) begin
            overrun <= 1'b0;
        end
    end

endmodule

// File: rtl/serial_rx_queue_timer.sv
// Character-timeout detector: counts bit ticks into character times and
// flags a timeout when TO_CHARS characters pass with data still queued.
// Assumes restart wins over expiry, and cancel wins over everything.
module serial_rx_queue_timer #(
    parameter  int TO_CHARS = 4,
    parameter  int TICK_W   = 4,
    localparam int CHR_W    = $clog2(TO_CHARS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cancel,
    input  logic              restart,
    input  logic              clear_pend,
    input  logic              occupied,
    input  logic              bit_tick,
    input  logic [TICK_W-1:0] char_len,
    output logic              pend
);

    logic              armed;
    logic [TICK_W-1:0] bit_cnt;
    logic [CHR_W-1:0]  chr_cnt;
    logic              char_done;
    logic              expire;

    // Detect the end of a character time and of the whole timeout window.
    always_comb begin
        char_done = armed && bit_tick && (bit_cnt >= char_len - 1'b1);
        expire    = char_done && (chr_cnt == CHR_W'(TO_CHARS - 1));
    end

    // Run the bit and character counters while armed.
    always_ff @(posedge clk) begin
        if (!rst_n || cancel) begin
            armed   <= 1'b0;
            bit_cnt <= '0;
            chr_cnt <= '0;
        end else if (restart) begin
            armed   <= 1'b1;
            bit_cnt <= '0;
            chr_cnt <= '0;
        end else if (expire) begin
            armed   <= 1'b0;
            bit_cnt <= '0;
            chr_cnt <= '0;
        end else if (char_done) begin
            bit_cnt <= '0;
            chr_cnt <= chr_cnt + 1'b1;
        end else if (armed && bit_tick) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Hold the timeout-pending flag until a pop or a receive flush.
    always_ff @(posedge clk) begin
        if (!rst_n || cancel) begin
            pend <= 1'b0;
        end else if (clear_pend) begin
            pend <= 1'b0;
        end else if (expire && !restart && occupied) begin
            pend <= 1'b1;
        end
    end

endmodule

// File: rtl/serial_rx_queue.sv
// Receive queue top: control register, byte store and timeout detector.
// Assumes one push and one pop strobe per cycle at most, from the
// deserialiser and the host respectively.
module serial_rx_queue
    import serial_rx_queue_pkg::*;
#(
    parameter  int DEPTH    = 16,
    parameter  int DW       = 8,
    parameter  int TO_CHARS = 4,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [DW-1:0]    pop_data,
    input  logic             bit_tick,
    input  logic [1:0]       data_sel,
    input  logic             parity_on,
    input  logic             stop_two,
    input  logic             ovr_clr,
    output logic [CNT_W-1:0] count,
    output logic             data_ready,
    output logic             trig_hit,
    output logic             timeout_pend,
    output logic             overrun,
    output logic [7:0]       ctl_q,
    output logic             tx_flush
);

    logic       rx_flush;
    logic       push_ok;
    logic       pop_ok;
    logic       restart;
    logic [3:0] char_len;
    logic [4:0] level;

    serial_rx_queue_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (ctl_we),
        .wdata      (ctl_wdata),
        .ctl_q      (ctl_q),
        .rx_flush   (rx_flush),
        .tx_flush_q (tx_flush)
    );

    serial_rx_queue_store #(
        .DEPTH (DEPTH),
        .DW    (DW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctl_q[EN_BIT]),
        .flush     (rx_flush),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .ovr_clr   (ovr_clr),
        .pop_data  (pop_data),
        .count     (count),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .overrun   (overrun)
    );

    // Frame length in ticks and restart condition for the timeout window.
    always_comb begin
        char_len = char_ticks(data_sel, parity_on, stop_two);
        restart  = push_ok || (pop_ok && (count > CNT_W'(1)));
    end

    serial_rx_queue_timer #(
        .TO_CHARS (TO_CHARS),
        .TICK_W   (4)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cancel     (rx_flush),
        .restart    (restart),
        .clear_pend (pop_ok),
        .occupied   (count != '0),
        .bit_tick   (bit_tick),
        .char_len   (char_len),
        .pend       (timeout_pend)
    );

    // Status outputs derived from occupancy and the trigger selector.
    always_comb begin
        level      = trig_level(ctl_q[7:6]);
        data_ready = (count != '0);
        trig_hit   = ctl_q[EN_BIT] && (count >= CNT_W'(level));
    end

endmodule

// File: rtl/serial_rx_queue_chk.sv
// Property checker for the receive queue, bound to every instance of the top.
module serial_rx_queue_chk #(
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic [7:0]       ctl_wdata,
    input logic             push,
    input logic             pop,
    input logic [CNT_W-1:0] count,
    input logic             data_ready,
    input logic             trig_hit,
    input logic             timeout_pend,
    input logic             overrun,
    input logic [7:0]       ctl_q,
    input logic             tx_flush
);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R2

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !ctl_we && count == CNT_W'(DEPTH)) |=> (count == CNT_W'(DEPTH) && overrun)); // R3

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !ctl_we && count == '0) |=> (count == '0)); // R4

    AST_TRIG_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |-> data_ready); // R6

    AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[1]) |=> (count == '0 && !timeout_pend)); // R8

    AST_TOGGLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && (ctl_wdata[0] != ctl_q[0])) |=> (count == '0 && tx_flush)); // R9

    AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[0] |-> (count == '0)); // R10

    AST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && ctl_q[0] && !ctl_we && count != '0) |=> !timeout_pend); // R13

endmodule

bind serial_rx_queue serial_rx_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_we       (ctl_we),
    .ctl_wdata    (ctl_wdata),
    .push         (push),
    .pop          (pop),
    .count        (count),
    .data_ready   (data_ready),
    .trig_hit     (trig_hit),
    .timeout_pend (timeout_pend),
    .overrun      (overrun),
    .ctl_q        (ctl_q),
    .tx_flush     (tx_flush)
);

// File: tb/test_serial_rx_queue.sv
// Directed bench for the receive queue: one task per scenario.
module test_serial_rx_queue;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       push = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop = 1'b0;
    logic [7:0] pop_data;
    logic       bit_tick = 1'b0;
    logic [1:0] data_sel = 2'd3;
    logic       parity_on = 1'b0;
    logic       stop_two = 1'b0;
    logic       ovr_clr = 1'b0;
    logic [4:0] count;
    logic       data_ready, trig_hit, timeout_pend, overrun, tx_flush;
    logic [7:0] ctl_q;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    serial_rx_queue i_serial_rx_queue (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .push(push), .push_data(push_data), .pop(pop), .pop_data(pop_data),
        .bit_tick(bit_tick), .data_sel(data_sel), .parity_on(parity_on),
        .stop_two(stop_two), .ovr_clr(ovr_clr), .count(count),
        .data_ready(data_ready), .trig_hit(trig_hit), .timeout_pend(timeout_pend),
        .overrun(overrun), .ctl_q(ctl_q), .tx_flush(tx_flush)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0; ctl_wdata = '0;
    endtask

    task automatic push_b(input logic [7:0] b);
        push = 1'b1; push_data = b;
        @(negedge clk);
        push = 1'b0;
    endtask

    task automatic pop_b(input string tag, input logic [7:0] exp);
        chk(tag, pop_data, exp);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            bit_tick = 1'b1;
            @(negedge clk);
        end
        bit_tick = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 count", count, 0);
        chk("R1 data_ready", data_ready, 0);
        chk("R1 trig_hit", trig_hit, 0);
        chk("R1 timeout_pend", timeout_pend, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 tx_flush", tx_flush, 0);
        chk("R1 ctl_q", ctl_q, 8'h00);
        chk("R1 pop_data", pop_data, 8'h00);
    endtask

    task automatic t_enable;
        wr_ctl(8'h01);
        chk("R7 enable stored", ctl_q, 8'h01);
        chk("R9 toggle pulses tx_flush", tx_flush, 1);
        @(negedge clk);
        chk("R8 tx_flush one cycle", tx_flush, 0);
    endtask

    task automatic t_fill_wrap;
        for (int i = 0; i < 16; i++) push_b(8'(i * 7 + 3));
        chk("R2 count full", count, 16);
        chk("R5 data_ready full", data_ready, 1);
        push_b(8'hEE);
        chk("R3 full push dropped", count, 16);
        chk("R3 overrun set", overrun, 1);
        for (int i = 0; i < 16; i++) pop_b("R2 order", 8'(i * 7 + 3));
        chk("R2 drained", count, 0);
        chk("R5 data_ready clears at zero", data_ready, 0);
        chk("R3 overrun sticky", overrun, 1);
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
        chk("R3 overrun cleared", overrun, 0);
        for (int i = 0; i < 10; i++) push_b(8'(8'h40 + i));
        for (int i = 0; i < 10; i++) pop_b("R2 partial", 8'(8'h40 + i));
        for (int i = 0; i < 12; i++) push_b(8'(8'h80 + i));
        chk("R2 count after wrap", count, 12);
        pop_b("R5 data_ready stays", 8'h80);
        chk("R5 data_ready with data", data_ready, 1);
        for (int i = 1; i < 12; i++) pop_b("R2 wrap order", 8'(8'h80 + i));
        chk("R2 empty after wrap", count, 0);
    endtask

    task automatic t_empty_pop;
        chk("R4 empty pop_data", pop_data, 8'h00);
        pop = 1'b1; @(negedge clk); @(negedge clk); pop = 1'b0;
        chk("R4 count unchanged", count, 0);
        chk("R4 overrun unchanged", overrun, 0);
        chk("R4 pend unchanged", timeout_pend, 0);
        push_b(8'h5A);
        pop_b("R4 head intact after empty pops", 8'h5A);
    endtask

    task automatic t_trigger;
        int lv[4] = '{1, 4, 8, 14};
        for (int s = 0; s < 4; s++) begin
            wr_ctl({2'(s), 6'b000001});
            chk("R7 trigger field stored", ctl_q, {2'(s), 6'b000001});
            chk("R8 no tx_flush without bit2", tx_flush, 0);
            for (int k = 0; k < lv[s] - 1; k++) push_b(8'(k));
            chk("R6 below threshold", trig_hit, 0);
            push_b(8'hA5);
            chk("R6 at threshold", trig_hit, 1);
            wr_ctl({2'(s), 6'b000011});
            chk("R8 rx flush empties", count, 0);
        end
        wr_ctl(8'h01);
    endtask

    task automatic t_mask_toggle;
        wr_ctl(8'hFF);
        chk("R7 retained mask", ctl_q, 8'hC9);
        chk("R8 bit2 pulses tx_flush", tx_flush, 1);
        wr_ctl(8'h01);
        chk("R7 rewrite", ctl_q, 8'h01);
        chk("R9 no toggle no tx_flush", tx_flush, 0);
        push_b(8'h11); push_b(8'h22); push_b(8'h33);
        wr_ctl(8'h00);
        chk("R9 toggle flushes rx", count, 0);
        chk("R9 toggle flushes tx", tx_flush, 1);
        push_b(8'h44); push_b(8'h55);
        chk("R10 disabled push ignored", count, 0);
        chk("R10 disabled no overrun", overrun, 0);
        wr_ctl(8'h01);
    endtask

    task automatic t_timeout;
        push_b(8'h61);
        ticks(39);
        chk("R12 before expiry", timeout_pend, 0);
        ticks(1);
        chk("R12 expiry at 4 chars", timeout_pend, 1);
        ticks(10);
        push_b(8'h62);
        chk("R13 push keeps pend", timeout_pend, 1);
        pop_b("R2 timeout data", 8'h61);
        chk("R13 pop clears pend", timeout_pend, 0);
        ticks(39);
        chk("R12 pop restart before", timeout_pend, 0);
        ticks(1);
        chk("R12 pop restart expiry", timeout_pend, 1);
        wr_ctl(8'h03);
        chk("R8 flush clears pend", timeout_pend, 0);
        chk("R8 flush empties", count, 0);
        ticks(50);
        chk("R8 timer cancelled", timeout_pend, 0);
        push_b(8'h71);
        ticks(30);
        push_b(8'h72);
        ticks(39);
        chk("R12 push restart before", timeout_pend, 0);
        ticks(1);
        chk("R12 push restart expiry", timeout_pend, 1);
        pop_b("R2 q1", 8'h71);
        pop_b("R2 q2", 8'h72);
        ticks(50);
        chk("R12 no pend when empty", timeout_pend, 0);
    endtask

    task automatic t_frame_len;
        data_sel = 2'd0; parity_on = 1'b1; stop_two = 1'b1;
        push_b(8'h81);
        ticks(35);
        chk("R11 9-tick frame before", timeout_pend, 0);
        ticks(1);
        chk("R11 9-tick frame expiry", timeout_pend, 1);
        wr_ctl(8'h03);
        data_sel = 2'd1; parity_on = 1'b0; stop_two = 1'b0;
        push_b(8'h82);
        ticks(31);
        chk("R11 8-tick frame before", timeout_pend, 0);
        ticks(1);
        chk("R11 8-tick frame expiry", timeout_pend, 1);
        wr_ctl(8'h03);
        data_sel = 2'd3;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_fill_wrap();
        t_empty_pop();
        t_trigger();
        t_mask_toggle();
        t_timeout();
        t_frame_len();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule